// File: doc/BRIEF.md
# DSP Condition Flag Datapath Slice

This block is one slice of a fixed-point DSP datapath. Every word is 40 bits wide: 32 data bits with 8 guard bits above them. On each cycle where the execute strobe is high, the slice runs one operation on two operands. The operation is an add, a subtract, a bitwise AND, OR or XOR, an arithmetic shift of the full 40-bit word, or a logical shift of the 32 data bits. The slice registers the 40-bit result.

The same strobe also updates one condition bit, called the decision flag. A 3-bit mode input selects what the flag tracks: carry or borrow, sign, zero, 32-bit overflow, signed greater-than, or signed greater-or-equal. The rule for each mode depends on two things: whether the operation is arithmetic or logical, and whether the guard bits count.

Downstream logic samples the registered flag to make conditional decisions. Everything that produces operands or consumes the flag lies outside this block.

Top module: `dsp_cond_unit`

## Requirements
- R1: Opcode 000 gives result = a + b and opcode 001 gives result = a - b. Both wrap at 40 bits. The result appears on `result` the cycle after the strobe.
- R2: Opcodes 010, 011 and 100 give a AND b, a OR b and a XOR b, applied over all 40 bits.
- R3: Opcode 101 is an arithmetic shift of the 40-bit operand a. The two's-complement `shamt` is applied as follows:
  - A positive value shifts left and a negative value shifts right, with the sign bit replicated.
  - A zero value passes a through unchanged.
  - Values beyond +32 are treated as +32, and values beyond -32 are treated as -32.
- R4: Opcode 110 is a logical shift of bits 31:0 of a. It uses the same amount rules as R3, with zero fill in both directions. Result bits 39:32 are cleared.
- R5: Flag mode 000 (carry) sets the flag as follows:
  - An add loads the carry out of bit 39.
  - A subtract loads the borrow, which is 1 when a < b unsigned.
  - Either shift loads the last bit shifted out, and a shift by zero leaves the flag unchanged.
  - AND, OR and XOR clear the flag.
- R6: Flag mode 001 (negative) loads result bit 39 for add, subtract and arithmetic shift. It loads result bit 31 for the logical operations and the logical shift.
- R7: Flag mode 010 (zero) sets the flag when all 40 result bits are zero and clears it otherwise.
- R8: Flag mode 011 (overflow) sets the flag for add, subtract or arithmetic shift when the true value does not fit a signed 32-bit range. That covers a 40-bit result outside [-2^31, 2^31-1], and any 40-bit over-range. Logical operations clear the flag.
- R9: Flag mode 101 (greater-or-equal) gives flag = NOT(bit39 XOR V40) for arithmetic operations. V40 means the true value does not fit 40 signed bits. Logical operations clear the flag.
- R10: Flag mode 100 (greater-than) gives flag = NOT((bit39 XOR V40) OR zero) for arithmetic operations. Logical operations clear the flag.
- R11: Flag modes 110 and 111 leave the flag unchanged, while the result still updates.
- R12: With the strobe low, or with opcode 111, both `result` and the flag hold.
- R13: A synchronous active-high reset clears `result` and the flag. Reset takes priority over the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe |
| op_sel | input | 3 | Operation code |
| cond_mode | input | 3 | Flag mode select |
| shamt | input | 7 | Signed shift amount |
| src_a | input | 40 | Operand a |
| src_b | input | 40 | Operand b |
| result | output | 40 | Registered result |
| dc | output | 1 | Registered decision flag |

## Verification
The bench aims at the places where the guard bits change the answer, with a specific wrong behaviour in mind for each:
- **0x7FFFFFFF + 1.** A design that judges overflow on bit 39 alone would miss the 32-bit overflow.
- **0x7FFFFFFFFF + 1.** A design that ignores 40-bit over-range would report the wrapped negative result as less-than.
- **Left shifts that push significant bits past bit 39, including ones that leave zero.** A wrong design would lose the over-range and flip the greater-than and greater-or-equal answers.
- **Shift amounts of zero, ±32 and beyond ±32.** These expose a design that reloads carry on a zero shift, picks the wrong last-out bit, or lets an out-of-range amount wrap.

A reference model drives checks under random mixes of opcodes, modes, strobes and reserved codes. Those checks catch a flag that moves when it should hold, or a logical shift that leaks guard bits.

// File: rtl/dsp_cond_pkg.sv
package dsp_cond_pkg;

   // Operation codes; the code values are part of the block's contract.
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_ASH = 3'd5,
      OP_LSH = 3'd6,
      OP_NOP = 3'd7
   } dsp_op_e;

   // Flag modes; codes 6 and 7 are reserved and freeze the flag.
   typedef enum logic [2:0] {
      CM_CARRY = 3'd0,
      CM_NEG   = 3'd1,
      CM_ZERO  = 3'd2,
      CM_OVF   = 3'd3,
      CM_GT    = 3'd4,
      CM_GE    = 3'd5,
      CM_RSV6  = 3'd6,
      CM_RSV7  = 3'd7
   } cond_mode_e;

   // Per-operation side information handed to the flag selector.
   typedef struct packed {
      logic carry;      // carry, borrow or last bit out
      logic carry_hold; // shift by zero: carry mode keeps the flag
      logic arith;      // arithmetic class (guard bits count)
      logic ovr_full;   // true value outside the full word range
   } op_info_t;

endpackage

// File: rtl/dsp_addsub.sv
module dsp_addsub #(
   parameter int W = 40
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         carry,
   output logic         ovr
);
   logic [W-1:0] b_eff;
   logic [W:0]   ext;

   always_comb begin
      b_eff = sub ? ~b : b;
      ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
      sum   = ext[W-1:0];
      // subtract: no carry out of the inverted add means a borrow
      carry = sub ? ~ext[W] : ext[W];
      ovr   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
   end
endmodule

// File: rtl/dsp_shift.sv
module dsp_shift #(
   parameter int W      = 40,
   parameter int SH_MAX = 32,
   parameter int AMT_W  = 7,
   parameter bit ARITH  = 1'b1
) (
   input  logic [W-1:0]     d,
   input  logic [AMT_W-1:0] mag,
   input  logic             left,
   output logic [W-1:0]     q,
   output logic             last_out,
   output logic             ovr
);
   localparam int FW = W + SH_MAX;

   logic          fill;
   logic [FW-1:0] up_v;
   logic [FW-1:0] dn_v;

   if (ARITH) begin : g_arith
      assign fill = d[W-1];
      assign dn_v = $signed({d, {SH_MAX{1'b0}}}) >>> mag;
      // fits only if every bit from W-1 upward still equals the sign
      assign ovr  = left && !((&up_v[FW-1:W-1]) || !(|up_v[FW-1:W-1]));
   end else begin : g_logic
      assign fill = 1'b0;
      assign dn_v = {d, {SH_MAX{1'b0}}} >> mag;
      assign ovr  = 1'b0;
   end

   assign up_v     = {{SH_MAX{fill}}, d} << mag;
   assign q        = left ? up_v[W-1:0] : dn_v[FW-1:SH_MAX];
   assign last_out = left ? up_v[W]     : dn_v[SH_MAX-1];
endmodule

// File: rtl/dsp_flag_sel.sv
module dsp_flag_sel
   import dsp_cond_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int GUARD_W = 8
) (
   input  logic [2:0]                mode,
   input  logic [DATA_W+GUARD_W-1:0] res,
   input  op_info_t                  info,
   output logic                      dc_next,
   output logic                      dc_keep
);
   localparam int W = DATA_W + GUARD_W;

   logic sgn, zero, fit_data, ovr_data, lt;

   always_comb begin
      sgn      = info.arith ? res[W-1] : res[DATA_W-1];
      zero     = (res == '0);
      fit_data = (&res[W-1:DATA_W-1]) || !(|res[W-1:DATA_W-1]);
      ovr_data = info.arith && (info.ovr_full || !fit_data);
      lt       = sgn ^ info.ovr_full;
      dc_next  = 1'b0;
      dc_keep  = 1'b0;
      unique case (cond_mode_e'(mode))
         CM_CARRY: begin
            dc_next = info.carry;
            dc_keep = info.carry_hold;
         end
         CM_NEG:  dc_next = sgn;
         CM_ZERO: dc_next = zero;
         CM_OVF:  dc_next = ovr_data;
         CM_GT:   dc_next = info.arith && !(lt || zero);
         CM_GE:   dc_next = info.arith && !lt;
         default: dc_keep = 1'b1;
      endcase
   end
endmodule

// File: rtl/dsp_cond_unit.sv
module dsp_cond_unit
   import dsp_cond_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int GUARD_W = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         exec_en,
   input  logic [2:0]                   op_sel,
   input  logic [2:0]                   cond_mode,
   input  logic [$clog2(DATA_W)+1:0]    shamt,
   input  logic [DATA_W+GUARD_W-1:0]    src_a,
   input  logic [DATA_W+GUARD_W-1:0]    src_b,
   output logic [DATA_W+GUARD_W-1:0]    result,
   output logic                         dc
);
   localparam int W    = DATA_W + GUARD_W;
   localparam int SH_W = $clog2(DATA_W) + 2;

   if (DATA_W < 2) begin : g_bad_data
      $error("dsp_cond_unit: DATA_W must be at least 2");
   end
   if (GUARD_W < 1) begin : g_bad_guard
      $error("dsp_cond_unit: GUARD_W must be at least 1");
   end

   // shift amount: sign gives direction, magnitude saturates at DATA_W
   logic            go_left;
   logic [SH_W-1:0] mag_raw, mag;
   always_comb begin
      go_left = !shamt[SH_W-1];
      mag_raw = go_left ? shamt : (~shamt + SH_W'(1));
      mag     = (mag_raw > SH_W'(DATA_W)) ? SH_W'(DATA_W) : mag_raw;
   end

   logic [W-1:0] as_sum;
   logic         as_carry, as_ovr;
   dsp_addsub #(.W(W)) i_addsub (
      .a(src_a), .b(src_b), .sub(op_sel == OP_SUB),
      .sum(as_sum), .carry(as_carry), .ovr(as_ovr)
   );

   logic [W-1:0] ash_q;
   logic         ash_last, ash_ovr;
   dsp_shift #(.W(W), .SH_MAX(DATA_W), .AMT_W(SH_W), .ARITH(1'b1)) i_ash (
      .d(src_a), .mag(mag), .left(go_left),
      .q(ash_q), .last_out(ash_last), .ovr(ash_ovr)
   );

   logic [DATA_W-1:0] lsh_q;
   logic              lsh_last, lsh_ovr;
   dsp_shift #(.W(DATA_W), .SH_MAX(DATA_W), .AMT_W(SH_W), .ARITH(1'b0)) i_lsh (
      .d(src_a[DATA_W-1:0]), .mag(mag), .left(go_left),
      .q(lsh_q), .last_out(lsh_last), .ovr(lsh_ovr)
   );

   logic [W-1:0] res_c;
   op_info_t     info;
   logic         upd;
   always_comb begin
      res_c = '0;
      info  = '0;
      upd   = 1'b1;
      unique case (dsp_op_e'(op_sel))
         OP_ADD, OP_SUB: begin
            res_c         = as_sum;
            info.carry    = as_carry;
            info.arith    = 1'b1;
            info.ovr_full = as_ovr;
         end
         OP_AND: res_c = src_a & src_b;
         OP_OR:  res_c = src_a | src_b;
         OP_XOR: res_c = src_a ^ src_b;
         OP_ASH: begin
            res_c           = ash_q;
            info.carry      = ash_last;
            info.carry_hold = (mag == '0);
            info.arith      = 1'b1;
            info.ovr_full   = ash_ovr;
         end
         OP_LSH: begin
            res_c           = {{GUARD_W{1'b0}}, lsh_q};
            info.carry      = lsh_last;
            info.carry_hold = (mag == '0);
            info.ovr_full   = lsh_ovr;
         end
         default: upd = 1'b0;
      endcase
   end

   logic dc_next, dc_keep;
   dsp_flag_sel #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) i_flag (
      .mode(cond_mode), .res(res_c), .info(info),
      .dc_next(dc_next), .dc_keep(dc_keep)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         dc     <= 1'b0;
      end else if (exec_en && upd) begin
         result <= res_c;
         if (!dc_keep) dc <= dc_next;
      end
   end
endmodule

// File: rtl/dsp_cond_unit_chk.sv
module dsp_cond_unit_chk
   import dsp_cond_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int GUARD_W = 8
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      exec_en,
   input logic [2:0]                op_sel,
   input logic [2:0]                cond_mode,
   input logic [DATA_W+GUARD_W-1:0] result,
   input logic                      dc
);
   logic bitwise_op, logical_op;
   assign bitwise_op = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_XOR);
   assign logical_op = bitwise_op || (op_sel == OP_LSH);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!exec_en || op_sel == OP_NOP) |=> ($stable(result) && $stable(dc))) else $error("idle hold"); // R12
   AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (exec_en && cond_mode[2:1] == 2'b11) |=> $stable(dc)) else $error("reserved hold"); // R11
   AST_CARRY_BITWISE_CLR: assert property (@(posedge clk) disable iff (rst)
      (exec_en && bitwise_op && cond_mode == CM_CARRY) |=> !dc) else $error("carry clr"); // R5
   AST_NEG_LOGICAL: assert property (@(posedge clk) disable iff (rst)
      (exec_en && logical_op && cond_mode == CM_NEG) |=> (dc == result[DATA_W-1])) else $error("neg"); // R6
   AST_ZERO_MODE: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op_sel != OP_NOP && cond_mode == CM_ZERO) |=> (dc == (result == '0))) else $error("zero"); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (exec_en && logical_op && cond_mode == CM_OVF) |=> !dc) else $error("ovf"); // R8
   AST_LOGIC_NO_GE: assert property (@(posedge clk) disable iff (rst)
      (exec_en && logical_op && cond_mode == CM_GE) |=> !dc) else $error("ge"); // R9
   AST_LOGIC_NO_GT: assert property (@(posedge clk) disable iff (rst)
      (exec_en && logical_op && cond_mode == CM_GT) |=> !dc) else $error("gt"); // R10
endmodule

bind dsp_cond_unit dsp_cond_unit_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) i_chk (
   .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
   .cond_mode(cond_mode), .result(result), .dc(dc)
);

// File: tb/test_dsp_cond_unit.sv
module test_dsp_cond_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        exec_en;
   logic [2:0]  op_sel, cond_mode;
   logic [6:0]  shamt;
   logic [39:0] src_a, src_b;
   logic [39:0] result;
   logic        dc;

   int total = 0, bad = 0;
   logic [39:0] exp_res;
   logic        exp_dc;
   bit          done = 0;

   localparam longint MAX40 = 64'sh7F_FFFF_FFFF;
   localparam longint MIN40 = -64'sh80_0000_0000;
   localparam longint MAX32 = 64'sh7FFF_FFFF;
   localparam longint MIN32 = -64'sh8000_0000;

   always #4 clk = ~clk;

   dsp_cond_unit i_dsp_cond_unit (
      .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
      .cond_mode(cond_mode), .shamt(shamt), .src_a(src_a), .src_b(src_b),
      .result(result), .dc(dc)
   );

   function automatic string res_tag(input logic [2:0] op);
      case (op)
         3'd0, 3'd1: return "R1";
         3'd2, 3'd3, 3'd4: return "R2";
         3'd5: return "R3";
         3'd6: return "R4";
         default: return "R12";
      endcase
   endfunction

   function automatic string dc_tag(input logic [2:0] op, input logic [2:0] md);
      if (op == 3'd7) return "R12";
      case (md)
         3'd0: return "R5";
         3'd1: return "R6";
         3'd2: return "R7";
         3'd3: return "R8";
         3'd4: return "R10";
         3'd5: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model of one strobed operation
   task automatic model(input logic [2:0] op, input logic [2:0] md, input logic [6:0] sh,
                        input logic [39:0] a, input logic [39:0] b, input logic en);
      longint sa, sb, ua, ub, tr, sr;
      int n, m;
      logic [39:0] r;
      logic [31:0] x;
      logic cy, hold, ar, ov, sg, zr, v32;
      if (!en || op == 3'd7) return;
      sa = longint'($signed(a)); sb = longint'($signed(b));
      ua = longint'(a);          ub = longint'(b);
      n = int'($signed(sh));
      if (n > 32) n = 32;
      if (n < -32) n = -32;
      cy = 0; hold = 0; ar = 0; ov = 0; r = '0; x = a[31:0];
      case (op)
         3'd0: begin tr = sa + sb; r = tr[39:0]; cy = ((ua + ub) >= 64'h100_0000_0000);
                     ar = 1; ov = (tr > MAX40) || (tr < MIN40); end
         3'd1: begin tr = sa - sb; r = tr[39:0]; cy = (ua < ub);
                     ar = 1; ov = (tr > MAX40) || (tr < MIN40); end
         3'd2: r = a & b;
         3'd3: r = a | b;
         3'd4: r = a ^ b;
         3'd5: begin
            ar = 1;
            if (n > 0) begin
               r = a << n; cy = a[40-n];
               sr = longint'($signed(r));
               ov = ((sr >>> n) != sa);
            end else if (n < 0) begin
               m = -n; r = 40'(sa >>> m); cy = a[m-1];
            end else begin
               r = a; hold = 1;
            end
         end
         default: begin
            if (n > 0) begin
               r = {8'h00, x << n}; cy = (n == 32) ? x[0] : x[32-n];
            end else if (n < 0) begin
               m = -n; r = {8'h00, x >> m}; cy = x[m-1];
            end else begin
               r = {8'h00, x}; hold = 1;
            end
         end
      endcase
      exp_res = r;
      sg = ar ? r[39] : r[31];
      zr = (r == '0);
      sr = longint'($signed(r));
      v32 = ar && (ov || sr > MAX32 || sr < MIN32);
      case (md)
         3'd0: if (!hold) exp_dc = cy;
         3'd1: exp_dc = sg;
         3'd2: exp_dc = zr;
         3'd3: exp_dc = v32;
         3'd4: exp_dc = ar && !((sg ^ ov) || zr);
         3'd5: exp_dc = ar && !(sg ^ ov);
         default: ;
      endcase
   endtask

   // called just after a falling edge; returns at the next falling edge
   task automatic do_op(input logic [2:0] op, input logic [2:0] md, input logic [6:0] sh,
                        input logic [39:0] a, input logic [39:0] b, input logic en);
      op_sel = op; cond_mode = md; shamt = sh; src_a = a; src_b = b; exec_en = en;
      model(op, md, sh, a, b, en);
      @(negedge clk);
      check(en ? res_tag(op) : "R12", result, exp_res);
      check(en ? dc_tag(op, md) : "R12", {39'd0, dc}, {39'd0, exp_dc});
   endtask

   task automatic do_reset();
      rst = 1; exec_en = 1; op_sel = 3'd0; cond_mode = 3'd2;
      src_a = 40'h12_3456_789A; src_b = 40'h1;
      @(negedge clk);
      exp_res = '0; exp_dc = 0;
      check("R13", result, 40'h0);
      check("R13", {39'd0, dc}, 40'h0);
      rst = 0;
   endtask

   function automatic logic [39:0] pick_operand();
      case ($urandom % 6)
         0: return {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
         1: return 40'(($urandom % 5));
         2: return 40'h7F_FFFF_FFFF - 40'($urandom % 3);
         3: return 40'h80_0000_0000 + 40'($urandom % 3);
         4: return 40'h00_7FFF_FFFF + 40'($urandom % 3) - 40'd1;
         default: return 40'hFF_FFFF_FFFF - 40'($urandom % 3);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      exp_res = '0; exp_dc = 0;
      rst = 1; exec_en = 0; op_sel = 0; cond_mode = 0; shamt = 0; src_a = 0; src_b = 0;
      @(negedge clk);
      do_reset();
      // R8: 0x7FFFFFFF + 1 leaves the 32-bit range
      do_op(3'd0, 3'd3, 7'd0, 40'h00_7FFF_FFFF, 40'h1, 1);
      do_op(3'd0, 3'd1, 7'd0, 40'h00_7FFF_FFFF, 40'h1, 1);     // R6 sign from bit 39
      // R9: 40-bit over-range flips the sign reading
      do_op(3'd0, 3'd5, 7'd0, 40'h7F_FFFF_FFFF, 40'h1, 1);
      do_op(3'd0, 3'd4, 7'd0, 40'h7F_FFFF_FFFF, 40'h1, 1);     // R10
      do_op(3'd0, 3'd0, 7'd0, 40'hFF_FFFF_FFFF, 40'h1, 1);     // R5 carry out
      do_op(3'd1, 3'd0, 7'd0, 40'h0, 40'h1, 1);                // R5 borrow
      do_op(3'd0, 3'd2, 7'd0, 40'h80_0000_0000, 40'h80_0000_0000, 1); // R7 wraps to zero
      do_op(3'd0, 3'd4, 7'd0, 40'h80_0000_0000, 40'h80_0000_0000, 1); // R10 zero with over-range
      do_op(3'd5, 3'd0, 7'd0, 40'h00_0000_0001, 40'h0, 1);     // R5 shift by zero holds
      do_op(3'd5, 3'd0, 7'd32, 40'h00_0000_0100, 40'h0, 1);    // R3 left 32, last out bit 8
      do_op(3'd5, 3'd5, 7'd8, 40'h01_0000_0000, 40'h0, 1);     // R3/R9 shifted to zero
      do_op(3'd5, 3'd0, 7'h40, 40'h80_8000_0000, 40'h0, 1);    // R3 -64 clamps to -32
      do_op(3'd6, 3'd1, 7'd4, 40'hAB_1800_0000, 40'h0, 1);     // R4 guard cleared
      do_op(3'd6, 3'd0, 7'h60, 40'hFF_8000_0001, 40'h0, 1);    // R4 right 32
      do_op(3'd2, 3'd3, 7'd0, 40'hFF_FFFF_FFFF, 40'h80_0000_0000, 1); // R8 logical clears
      do_op(3'd0, 3'd0, 7'd0, 40'hFF_FFFF_FFFF, 40'h1, 1);
      do_op(3'd1, 3'd6, 7'd0, 40'h5, 40'h7, 1);                // R11 flag frozen
      do_op(3'd3, 3'd7, 7'd0, 40'h0, 40'h0, 1);                // R11
      do_op(3'd7, 3'd2, 7'd0, 40'h0, 40'h0, 1);                // R12 no-op
      do_op(3'd4, 3'd2, 7'd0, 40'h3, 40'h3, 0);                // R12 strobe low
      for (int i = 0; i < 6000; i++) begin
         logic [6:0] sh;
         if (i == 3000) do_reset();
         sh = ($urandom % 4 == 0) ? 7'($urandom) : 7'(($urandom % 65) - 32);
         do_op(3'($urandom), 3'($urandom), sh, pick_operand(), pick_operand(),
               ($urandom % 8) != 0);
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule